// File: doc/BRIEF.md
# Slack-Predicting Fetch Throttle

This front-end controller holds back instruction fetch for fetch groups that are expected to meet idle stall time further down the pipeline. Each fetch group maps to one entry of a small prediction table, indexed by the same index the branch target buffer uses. An entry holds a learned slack value, in cycles, and a two-bit confidence counter. When a group asks to fetch and its entry is confident with a non-zero slack, the grant is postponed by that slack. The clock enable of the front-end stage latches is pulled low for exactly the postponed cycles.

When a group retires, the back end reports the stall slack it actually saw. The table keeps that value, clipped to the pipeline depth, and moves the confidence up or down according to whether the old prediction was met. A misprediction flush or a redirect ends any hold at once. The requester keeps its request and index steady until it is granted. A retire update and a lookup of the same entry in the same cycle see the value from before the update.

Top module: `slack_fetch_throttle`

## Requirements
- R1: After reset every entry has slack 0 and confidence 0. With no request, `fe_clk_en_o` is 1 and `fetch_go_o` is 0. The first request to any entry is granted in the cycle it is raised.
- R2: A request whose entry has confidence below CONF_TH (default 2) is granted in the same cycle. `fe_clk_en_o` stays 1.
- R3: A request whose entry has confidence of at least CONF_TH and slack S > 0 is granted exactly S cycles after the cycle in which it was first raised. `fetch_go_o` is 0 in the cycles between.
- R4: During such a hold, `fe_clk_en_o` is 0 in the request cycle and the S-1 cycles after it, and 1 in the grant cycle. `fe_clk_en_o` is never 0 in a cycle where `fetch_go_o` is 1.
- R5: A confident entry whose slack is 0 causes no delay and no gating.
- R6: On `retire_vld_i`, the entry's slack becomes min(`retire_slack_i`, PIPE_DEPTH). No hold lasts longer than PIPE_DEPTH cycles.
- R7: On `retire_vld_i`, confidence goes up by one when the clipped measured slack is at least the stored slack, and down by one otherwise. It saturates at 3 and at 0.
- R8: `flush_i` in a gated cycle ends the hold. In the next cycle `fe_clk_en_o` is 1 and the still-pending request is granted.
- R9: `fetch_go_o` is 1 only in a cycle where `fetch_req_i` is 1.
- R10: A retire update changes only the entry named by `retire_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req_i | input | 1 | A fetch group requests fetch; held until granted |
| fetch_idx_i | input | IDX_W | Table index of the requesting group |
| fetch_go_o | output | 1 | Fetch granted this cycle |
| fe_clk_en_o | output | 1 | Clock enable for the front-end stage latches |
| flush_i | input | 1 | Misprediction flush or redirect; ends any hold |
| retire_vld_i | input | 1 | A fetch group retires and reports its slack |
| retire_idx_i | input | IDX_W | Table index of the retiring group |
| retire_slack_i | input | MEAS_W | Measured stall slack of the retiring group |

## Verification
Directed sequences build up one entry at a time. Repeated large measured slacks check the clipping to the pipeline depth. A smaller measurement after that checks that confidence falls back below the threshold. Runs of zero-slack retires show that a confident zero does not gate, and drive confidence into saturation at both ends. A retire after the low saturation tells a saturating counter apart from a wrapping one. A flush at a chosen cycle inside a hold shows that the grant moves up to the very next cycle. Random interleaving of retires and fetches across all entries, with random flush points, is compared against a bench model of the table. This exposes any update that leaks into another entry and any off-by-one in the hold length.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RELEASE = 2'd2
    } hold_st_e;

    localparam int CONF_W   = 2;
    localparam int CONF_MAX = (1 << CONF_W) - 1;

endpackage

// File: rtl/sft_slack_table.sv
module sft_slack_table
    import sft_pkg::*;
#(
    parameter int PIPE_DEPTH = 6,
    parameter int ENTRIES    = 16,
    parameter int MEAS_W     = 8,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int SLK_W     = $clog2(PIPE_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [SLK_W-1:0]  rd_slack_o,
    output logic [CONF_W-1:0] rd_conf_o,
    input  logic              upd_vld_i,
    input  logic [IDX_W-1:0]  upd_idx_i,
    input  logic [MEAS_W-1:0] upd_slack_i
);

    localparam logic [MEAS_W-1:0] DEPTH_M = MEAS_W'(PIPE_DEPTH);
    localparam logic [SLK_W-1:0]  DEPTH_S = SLK_W'(PIPE_DEPTH);

    typedef struct packed {
        logic [ENTRIES-1:0][SLK_W-1:0]  slk;
        logic [ENTRIES-1:0][CONF_W-1:0] conf;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [SLK_W-1:0] clipped;
    logic             met;

    always_comb begin
        tbl_d   = tbl_q;
        clipped = (upd_slack_i > DEPTH_M) ? DEPTH_S : upd_slack_i[SLK_W-1:0];
        met     = clipped >= tbl_q.slk[upd_idx_i];
        for (int e = 0; e < ENTRIES; e++) begin
            if (upd_vld_i && (upd_idx_i == IDX_W'(e))) begin
                tbl_d.slk[e] = clipped;
                if (met) begin
                    if (tbl_q.conf[e] != CONF_W'(CONF_MAX))
                        tbl_d.conf[e] = tbl_q.conf[e] + 1'b1;
                end else begin
                    if (tbl_q.conf[e] != '0)
                        tbl_d.conf[e] = tbl_q.conf[e] - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd_slack_o = tbl_q.slk[rd_idx_i];
    assign rd_conf_o  = tbl_q.conf[rd_idx_i];

endmodule

// File: rtl/sft_delay_ctl.sv
module sft_delay_ctl
    import sft_pkg::*;
#(
    parameter int SLK_W   = 3,
    parameter int CONF_TH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [SLK_W-1:0]  slack_i,
    input  logic [CONF_W-1:0] conf_i,
    input  logic              flush_i,
    output logic              go_o,
    output logic              clk_en_o
);

    typedef struct packed {
        hold_st_e         st;
        logic [SLK_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic confident;

    always_comb begin
        ctl_d     = ctl_q;
        go_o      = 1'b0;
        clk_en_o  = 1'b1;
        confident = (conf_i >= CONF_W'(CONF_TH)) && (slack_i != '0);
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    if (confident) begin
                        clk_en_o = 1'b0;
                        if (flush_i || slack_i == SLK_W'(1)) begin
                            ctl_d.st = ST_RELEASE;
                        end else begin
                            ctl_d.st  = ST_HOLD;
                            ctl_d.cnt = slack_i - SLK_W'(1);
                        end
                    end else begin
                        go_o = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                clk_en_o = 1'b0;
                if (flush_i || ctl_q.cnt == SLK_W'(1)) begin
                    ctl_d.st = ST_RELEASE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - SLK_W'(1);
                end
            end
            ST_RELEASE: begin
                go_o = req_i;
                if (req_i) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.cnt <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/slack_fetch_throttle.sv
module slack_fetch_throttle
    import sft_pkg::*;
#(
    parameter int PIPE_DEPTH = 6,
    parameter int ENTRIES    = 16,
    parameter int MEAS_W     = 8,
    parameter int CONF_TH    = 2,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req_i,
    input  logic [IDX_W-1:0]  fetch_idx_i,
    output logic              fetch_go_o,
    output logic              fe_clk_en_o,
    input  logic              flush_i,
    input  logic              retire_vld_i,
    input  logic [IDX_W-1:0]  retire_idx_i,
    input  logic [MEAS_W-1:0] retire_slack_i
);

    localparam int SLK_W = $clog2(PIPE_DEPTH + 1);

    logic [SLK_W-1:0]  lk_slack;
    logic [CONF_W-1:0] lk_conf;

    sft_slack_table #(
        .PIPE_DEPTH (PIPE_DEPTH),
        .ENTRIES    (ENTRIES),
        .MEAS_W     (MEAS_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx_i    (fetch_idx_i),
        .rd_slack_o  (lk_slack),
        .rd_conf_o   (lk_conf),
        .upd_vld_i   (retire_vld_i),
        .upd_idx_i   (retire_idx_i),
        .upd_slack_i (retire_slack_i)
    );

    sft_delay_ctl #(
        .SLK_W   (SLK_W),
        .CONF_TH (CONF_TH)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (fetch_req_i),
        .slack_i  (lk_slack),
        .conf_i   (lk_conf),
        .flush_i  (flush_i),
        .go_o     (fetch_go_o),
        .clk_en_o (fe_clk_en_o)
    );

endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
    parameter int PIPE_DEPTH = 6
) (
    input logic clk,
    input logic rst_n,
    input logic fetch_req_i,
    input logic fetch_go_o,
    input logic fe_clk_en_o,
    input logic flush_i
);

    logic [7:0] gated_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              gated_run_q <= '0;
        else if (fe_clk_en_o)    gated_run_q <= '0;
        else if (gated_run_q != 8'hFF) gated_run_q <= gated_run_q + 8'd1;
    end

    // R4: gating and grant never coincide
    assert_gate_excl_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_clk_en_o |-> !fetch_go_o);

    // R9: a grant needs a live request
    assert_go_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go_o |-> fetch_req_i);

    // R8: flush in a gated cycle releases fetch next cycle
    assert_flush_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !fe_clk_en_o && fetch_req_i) |=> (fe_clk_en_o && (fetch_go_o == fetch_req_i)));

    // R6: a hold never lasts beyond the pipeline depth
    assert_hold_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_clk_en_o |-> (gated_run_q < 8'(PIPE_DEPTH)));

    // R3: gating only starts on a pending, ungranted request
    assert_gate_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_clk_en_o && !fetch_go_o) |=> (fe_clk_en_o || fetch_req_i));

endmodule

bind slack_fetch_throttle sft_checker #(.PIPE_DEPTH(PIPE_DEPTH)) u_sft_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req_i (fetch_req_i),
    .fetch_go_o  (fetch_go_o),
    .fe_clk_en_o (fe_clk_en_o),
    .flush_i     (flush_i)
);

// File: tb/slack_fetch_throttle_bench.sv
module slack_fetch_throttle_bench;

    localparam int DEPTH   = 6;
    localparam int ENTRIES = 16;
    localparam int MEAS_W  = 8;
    localparam int IDX_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_req_i = 1'b0;
    logic [IDX_W-1:0]  fetch_idx_i = '0;
    logic              fetch_go_o;
    logic              fe_clk_en_o;
    logic              flush_i = 1'b0;
    logic              retire_vld_i = 1'b0;
    logic [IDX_W-1:0]  retire_idx_i = '0;
    logic [MEAS_W-1:0] retire_slack_i = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int m_slk  [ENTRIES];
    int m_conf [ENTRIES];

    always #2 clk = ~clk;

    slack_fetch_throttle #(.PIPE_DEPTH(DEPTH), .ENTRIES(ENTRIES), .MEAS_W(MEAS_W), .CONF_TH(2))
    u_slack_fetch_throttle (
        .clk(clk), .rst_n(rst_n), .fetch_req_i(fetch_req_i), .fetch_idx_i(fetch_idx_i),
        .fetch_go_o(fetch_go_o), .fe_clk_en_o(fe_clk_en_o), .flush_i(flush_i),
        .retire_vld_i(retire_vld_i), .retire_idx_i(retire_idx_i), .retire_slack_i(retire_slack_i)
    );

    function automatic int exp_delay(int idx);
        return (m_conf[idx] >= 2 && m_slk[idx] != 0) ? m_slk[idx] : 0;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R7 R6 R10: model update of one entry
    task automatic do_retire(int idx, int meas);
        int clip;
        @(negedge clk);
        retire_vld_i   = 1'b1;
        retire_idx_i   = IDX_W'(idx);
        retire_slack_i = MEAS_W'(meas);
        #1;
        check(!fetch_go_o, "R9 no grant without request", int'(fetch_go_o), 0);
        clip = (meas > DEPTH) ? DEPTH : meas;
        if (clip >= m_slk[idx]) begin if (m_conf[idx] < 3) m_conf[idx]++; end
        else                    begin if (m_conf[idx] > 0) m_conf[idx]--; end
        m_slk[idx] = clip;
        @(negedge clk);
        retire_vld_i = 1'b0;
    endtask

    task automatic do_fetch(int idx, int flush_at, string tag);
        int d, go_at, k, gate_bad;
        d     = exp_delay(idx);
        go_at = (flush_at >= 0 && flush_at < d) ? flush_at + 1 : d;
        k = 0; gate_bad = 0;
        @(negedge clk);
        fetch_req_i = 1'b1;
        fetch_idx_i = IDX_W'(idx);
        forever begin
            flush_i = (k == flush_at);
            #1;
            if (fe_clk_en_o != !(k < go_at)) gate_bad++;
            if (fetch_go_o || k > 3 * DEPTH) break;
            @(negedge clk);
            k++;
        end
        check(k == go_at, tag, k, go_at);
        check(gate_bad == 0, {tag, " R4 gating pattern"}, gate_bad, 0);
        @(negedge clk);
        fetch_req_i = 1'b0;
        flush_i     = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < ENTRIES; i++) begin m_slk[i] = 0; m_conf[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(fe_clk_en_o == 1'b1, "R1 clk enable after reset", int'(fe_clk_en_o), 1);
        check(fetch_go_o == 1'b0, "R1 no grant after reset", int'(fetch_go_o), 0);
        do_fetch(0, -1, "R1 first fetch undelayed");

        // R6: big measured slack clips to depth
        do_retire(3, 9);
        do_fetch(3, -1, "R2 low confidence no delay");
        do_retire(3, 9);
        do_fetch(3, -1, "R6 R3 clipped delay equals depth");
        do_fetch(3, 2, "R8 flush releases early");
        do_fetch(3, 0, "R8 flush in request cycle");
        do_retire(3, 2);
        do_fetch(3, -1, "R7 confidence falls below threshold");
        do_retire(3, 2);
        do_fetch(3, -1, "R3 delay of two");
        do_fetch(4, -1, "R10 neighbour untouched");

        // R5 and high saturation
        repeat (4) do_retire(5, 0);
        do_fetch(5, -1, "R5 confident zero slack");
        do_retire(5, 4);
        do_fetch(5, -1, "R7 saturated high then delay four");
        do_retire(5, 1);
        do_fetch(5, -1, "R3 delay of one");

        // R7 low saturation
        do_retire(7, 3);
        do_retire(7, 1);
        do_retire(7, 0);
        do_retire(7, 2);
        do_fetch(7, -1, "R7 saturated low no wrap");

        for (int n = 0; n < 600; n++) begin
            int idx;
            idx = int'($urandom % ENTRIES);
            if ($urandom % 2 == 0) begin
                do_retire(idx, int'($urandom % 11));
            end else begin
                int fa;
                fa = ($urandom % 4 == 0) ? int'($urandom % (DEPTH + 1)) : -1;
                do_fetch(idx, fa, "R3 R10 random fetch");
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule